// File: doc/BRIEF.md
# 100 Mb/s Receive Carrier Sense Detector

This block sits on the receive side of a 100 Mb/s physical layer. The descrambler delivers 5-bit code-group bits one at a time, each marked by a strobe. From these bits the block derives carrier sense.

Receive carrier rises as soon as line activity appears in the raw code bits. The block then hunts for the start delimiter, which is two code groups long. If it finds the delimiter, it locks 5-bit symbol alignment to it and holds carrier until one of two endings arrives: the two-symbol end delimiter, or two idle symbols in a row. If it does not find the delimiter, a long run of ones marks the activity as a false carrier and carrier drops.

Transmit enable is merged into the output when the port runs half duplex and is not acting as a repeater. This lets the MAC see its own transmissions as carrier.

Top module: `crs_detect`

## Requirements
- R1: While the synchronous active-low reset is held, and on the first cycle after it is released, crs is low as long as tx_en is low. Reset also sets the bit history to all ones.
- R2: Receive carrier rises when the last ten strobed bits hold two zeros that are not adjacent to each other. A lone pair of adjacent zeros, followed by ones, leaves carrier low.
- R3: If ten consecutive strobed ones arrive after carrier has risen but before the start delimiter, receive carrier drops on that tenth one.
- R4: The start delimiter is the ten-bit sequence 11000 then 10001, in arrival order. It fixes symbol alignment, so the next strobed bit is the first bit of a symbol, and a code group is read first bit as its most significant bit.
- R5: Inside a frame, a symbol 01101 followed immediately by the symbol 00111 drops receive carrier when the last bit of the second symbol is strobed.
- R6: Inside a frame, two consecutive 11111 symbols drop receive carrier when the last bit of the second one is strobed.
- R7: A 01101 symbol not followed by 00111, or a 11111 symbol followed by any other symbol, keeps carrier up.
- R8: With full_duplex or repeater_mode high, crs reflects receive activity only, whatever tx_en does.
- R9: With both full_duplex and repeater_mode low, crs is high whenever tx_en is high, in the same cycle and with no register in the path.
- R10: Bits presented while bit_valid is low are ignored: they change neither carrier nor the bit history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | Strobe: rx_bit is taken on this edge |
| rx_bit | input | 1 | Descrambled code-group bit |
| tx_en | input | 1 | Transmit activity from the MAC |
| full_duplex | input | 1 | Full-duplex operation selected |
| repeater_mode | input | 1 | Port acts as a repeater |
| crs | output | 1 | Carrier sense |

## Verification
The receive part of crs is registered. It changes at the clock edge that takes the strobed bit which completes an event, so it is due one cycle after that bit is presented. The transmit part follows tx_en, full_duplex and repeater_mode within the same cycle.

The bench drives every input at the falling edge and compares crs shortly afterwards. Each comparison therefore sees the receive state left by the previous rising edge, combined with the transmit inputs that were just set. A bit-level reference model advances only at the rising edge that takes a strobed bit. Directed checks place their expectations directly after the bit that completes the event, and once more just before it.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int SYM_W   = 5;
  localparam int WIN_LEN = 10;

  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

  typedef enum logic [1:0] {
    RX_QUIET = 2'd0,
    RX_HUNT  = 2'd1,
    RX_FRAME = 2'd2
  } rx_state_e;
endpackage

// File: rtl/crs_window.sv
module crs_window
  import crs_pkg::*;
#(
  parameter int W  = WIN_LEN,
  parameter int SW = SYM_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  input  logic clear,
  output logic act_evt,
  output logic ones_evt,
  output logic jk_evt
);
  localparam int DW = 2 * SW;

  logic [W-1:0] hist_q;
  logic [W-1:0] hist_nxt;

  // true when the window holds two zeros at least two positions apart
  function automatic logic spread_zeros(input logic [W-1:0] w);
    int lo;
    int hi;
    lo = -1;
    hi = -1;
    for (int i = 0; i < W; i++) begin
      if (!w[i]) begin
        if (lo < 0) lo = i;
        hi = i;
      end
    end
    return (lo >= 0) && ((hi - lo) >= 2);
  endfunction

  assign hist_nxt = {hist_q[W-2:0], bit_in};
  assign act_evt  = shift_en & spread_zeros(hist_nxt);
  assign ones_evt = shift_en & (&hist_nxt);
  assign jk_evt   = shift_en & (hist_nxt[DW-1:0] == {CG_J, CG_K});

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '1;
    else if (shift_en) hist_q <= clear ? '1 : hist_nxt;
  end

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/crs_symbol.sv
module crs_symbol
  import crs_pkg::*;
#(
  parameter int SW = SYM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic          align,
  output logic          sym_done,
  output logic [SW-1:0] sym_val
);
  localparam int CW = $clog2(SW);
  localparam logic [CW-1:0] LAST = CW'(SW - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-2:0] part_q;

  assign sym_val  = {part_q, bit_in};
  assign sym_done = shift_en & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (shift_en) begin
      part_q <= sym_val[SW-2:0];
      if (align || cnt_q == LAST) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  sym_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4
  sym_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> (cnt_q == '0));
endmodule

// File: rtl/crs_detect.sv
module crs_detect
  import crs_pkg::*;
#(
  parameter int W  = WIN_LEN,
  parameter int SW = SYM_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic rx_bit,
  input  logic tx_en,
  input  logic full_duplex,
  input  logic repeater_mode,
  output logic crs
);
  rx_state_e     st_q;
  logic          pend_t_q;
  logic          pend_i_q;

  logic          act_evt;
  logic          ones_evt;
  logic          jk_evt;
  logic          sym_done;
  logic [SW-1:0] sym_val;

  logic          start_evt;
  logic          false_evt;
  logic          lock_evt;
  logic          end_evt;
  logic          hist_clear;
  logic          rx_active;
  logic          tx_merge;

  crs_window #(.W(W), .SW(SW)) win_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_valid),
    .bit_in   (rx_bit),
    .clear    (hist_clear),
    .act_evt  (act_evt),
    .ones_evt (ones_evt),
    .jk_evt   (jk_evt)
  );

  crs_symbol #(.SW(SW)) sym_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_valid),
    .bit_in   (rx_bit),
    .align    (lock_evt),
    .sym_done (sym_done),
    .sym_val  (sym_val)
  );

  assign start_evt  = (st_q == RX_QUIET) & act_evt;
  assign lock_evt   = (st_q == RX_HUNT) & jk_evt;
  assign false_evt  = (st_q == RX_HUNT) & ~jk_evt & ones_evt;
  assign end_evt    = (st_q == RX_FRAME) & sym_done &
                      ((pend_t_q & (sym_val == CG_R)) |
                       (pend_i_q & (sym_val == CG_IDLE)));
  assign hist_clear = false_evt | end_evt;

  assign rx_active  = (st_q != RX_QUIET);
  assign tx_merge   = tx_en & ~full_duplex & ~repeater_mode;
  assign crs        = rx_active | tx_merge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= RX_QUIET;
      pend_t_q <= 1'b0;
      pend_i_q <= 1'b0;
    end else begin
      if (start_evt) st_q <= RX_HUNT;
      if (false_evt) st_q <= RX_QUIET;
      if (lock_evt) begin
        st_q     <= RX_FRAME;
        pend_t_q <= 1'b0;
        pend_i_q <= 1'b0;
      end
      if (end_evt) begin
        st_q     <= RX_QUIET;
        pend_t_q <= 1'b0;
        pend_i_q <= 1'b0;
      end else if ((st_q == RX_FRAME) && sym_done) begin
        pend_t_q <= (sym_val == CG_T);
        pend_i_q <= (sym_val == CG_IDLE);
      end
    end
  end

  // R2
  rise_from_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(start_evt));
  // R3
  false_carrier_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    false_evt |=> !rx_active);
  // R4
  lock_to_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> (st_q == RX_FRAME));
  // R5
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !rx_active);
  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RX_FRAME) && sym_done && !end_evt) |=> rx_active);
  // R8
  rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_duplex || repeater_mode) && !rx_active) |-> !crs);
  // R9
  tx_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !full_duplex && !repeater_mode) |-> crs);
  // R10
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(st_q));
endmodule

// File: tb/crs_detect_tb_top.sv
module crs_detect_tb_top;
  localparam int PERIOD = 10;
  localparam logic [4:0] SJ = 5'b11000, SK = 5'b10001, ST = 5'b01101,
                         SR = 5'b00111, SI = 5'b11111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic rx_bit = 1'b1;
  logic tx_en = 1'b0;
  logic full_duplex = 1'b0;
  logic repeater_mode = 1'b0;
  logic crs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int gap_pct = 0;

  // reference model state
  int m_st = 0;
  bit m_w [10];
  int m_cnt = 0;
  bit [4:0] m_acc = '0;
  bit m_pt = 1'b0;
  bit m_pi = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  crs_detect dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .tx_en(tx_en), .full_duplex(full_duplex), .repeater_mode(repeater_mode),
    .crs(crs)
  );

  function automatic bit m_activity();
    int zc = 0;
    bit adj = 1'b0;
    for (int i = 0; i < 10; i++) if (!m_w[i]) zc++;
    for (int i = 0; i < 9; i++) if (!m_w[i] && !m_w[i+1]) adj = 1'b1;
    return (zc >= 3) || (zc == 2 && !adj);
  endfunction

  function automatic bit m_exp();
    return (m_st != 0) || (tx_en && !full_duplex && !repeater_mode);
  endfunction

  task automatic m_fill_ones();
    for (int i = 0; i < 10; i++) m_w[i] = 1'b1;
  endtask

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_acc = '0; m_pt = 0; m_pi = 0;
    m_fill_ones();
  endtask

  task automatic m_step(input bit b);
    bit [9:0] v;
    bit ones;
    for (int i = 9; i > 0; i--) m_w[i] = m_w[i-1];
    m_w[0] = b;
    ones = 1'b1;
    for (int i = 0; i < 10; i++) begin
      v[i] = m_w[i];
      if (!m_w[i]) ones = 1'b0;
    end
    case (m_st)
      0: if (m_activity()) m_st = 1;
      1: begin
        if (v == {SJ, SK}) begin
          m_st = 2; m_cnt = 0; m_pt = 0; m_pi = 0;
        end else if (ones) begin
          m_st = 0; m_fill_ones();
        end
      end
      default: begin
        m_acc = {m_acc[3:0], b};
        m_cnt++;
        if (m_cnt == 5) begin
          m_cnt = 0;
          if ((m_pt && m_acc == SR) || (m_pi && m_acc == SI)) begin
            m_st = 0; m_pt = 0; m_pi = 0; m_fill_ones();
          end else begin
            m_pt = (m_acc == ST);
            m_pi = (m_acc == SI);
          end
        end
      end
    endcase
  endtask

  task automatic chk(input string tag);
    bit e;
    e = m_exp();
    n_chk++;
    if (crs !== e) begin
      n_bad++;
      $display("FAIL %s: crs=%b expected %b (model)", tag, crs, e);
    end
  endtask

  task automatic expect_crs(input bit e, input string tag);
    @(negedge clk);
    bit_valid = 1'b0;
    #1;
    n_chk++;
    if (crs !== e) begin
      n_bad++;
      $display("FAIL %s: crs=%b expected %b", tag, crs, e);
    end
  endtask

  task automatic cyc(input bit v, input bit b, input string tag);
    @(negedge clk);
    bit_valid = v;
    rx_bit = b;
    #1;
    chk(tag);
    @(posedge clk);
    if (rst_n && v) m_step(b);
  endtask

  task automatic send_bit(input bit b, input string tag);
    while (($urandom % 100) < gap_pct) cyc(1'b0, ~b, tag);
    cyc(1'b1, b, tag);
  endtask

  task automatic send_sym(input bit [4:0] s, input string tag);
    for (int i = 4; i >= 0; i--) send_bit(s[i], tag);
  endtask

  task automatic send_ones(input int n, input string tag);
    for (int i = 0; i < n; i++) send_bit(1'b1, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bit_valid = 1'b0;
    repeat (3) @(posedge clk);
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    do_reset();
    expect_crs(1'b0, "R1 reset state");

    // R10: unstrobed zeros are ignored
    for (int i = 0; i < 12; i++) cyc(1'b0, i[0], "R10 unstrobed");
    expect_crs(1'b0, "R10 unstrobed zeros ignored");

    // R2: adjacent zero pair alone does not start carrier
    send_ones(5, "R2"); send_bit(0, "R2"); send_bit(0, "R2");
    send_ones(10, "R2");
    expect_crs(1'b0, "R2 adjacent zeros only");
    send_bit(0, "R2"); send_bit(1, "R2"); send_bit(0, "R2");
    expect_crs(1'b1, "R2 separated zeros start carrier");

    // R3: false carrier on ten ones
    send_ones(9, "R3");
    expect_crs(1'b1, "R3 nine ones keep carrier");
    send_bit(1, "R3");
    expect_crs(1'b0, "R3 tenth one drops carrier");

    // R4 R7 R5: full frame with lone T and lone idle
    send_sym(SI, "R4"); send_sym(SJ, "R4"); send_sym(SK, "R4");
    expect_crs(1'b1, "R4 delimiter locked");
    send_sym(5'b01110, "R4"); send_ones(5, "R4"); send_sym(5'b11110, "R4");
    expect_crs(1'b1, "R4 ones in frame keep carrier");
    send_sym(ST, "R7"); send_sym(5'b10101, "R7");
    expect_crs(1'b1, "R7 lone T keeps carrier");
    send_sym(SI, "R7"); send_sym(5'b01010, "R7");
    expect_crs(1'b1, "R7 lone idle keeps carrier");
    send_sym(ST, "R5");
    for (int i = 4; i > 0; i--) send_bit(SR[i], "R5");
    expect_crs(1'b1, "R5 before last bit of end pair");
    send_bit(SR[0], "R5");
    expect_crs(1'b0, "R5 end delimiter drops carrier");

    // R6: two idles end the frame
    send_sym(SJ, "R6"); send_sym(SK, "R6"); send_sym(5'b10110, "R6");
    send_sym(SI, "R6"); send_ones(4, "R6");
    expect_crs(1'b1, "R6 before second idle completes");
    send_bit(1, "R6");
    expect_crs(1'b0, "R6 two idles drop carrier");

    // R8 R9: transmit merge
    tx_en = 1'b1;
    expect_crs(1'b1, "R9 tx_en in half duplex");
    full_duplex = 1'b1;
    expect_crs(1'b0, "R8 full duplex ignores tx_en");
    full_duplex = 1'b0; repeater_mode = 1'b1;
    expect_crs(1'b0, "R8 repeater ignores tx_en");
    tx_en = 1'b0; repeater_mode = 1'b0;
    expect_crs(1'b0, "R9 tx_en low");

    // R10: gaps inside a frame
    gap_pct = 60;
    send_sym(SJ, "R10"); send_sym(SK, "R10"); send_sym(5'b01011, "R10");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, "R10 gap");
    expect_crs(1'b1, "R10 gaps hold frame carrier");
    send_sym(ST, "R10"); send_sym(SR, "R10");
    expect_crs(1'b0, "R10 gapped frame end");

    // random phase: R2 R3 R4 R5 R6 R7 R8 R9 R10 against the model
    gap_pct = 25;
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom % 16;
      if (($urandom % 8) == 0) begin
        tx_en = $urandom; full_duplex = $urandom; repeater_mode = $urandom;
      end
      case (r)
        0, 1, 2, 3: send_sym(SI, "random idle R6");
        4, 5:       begin send_sym(SJ, "random R4"); send_sym(SK, "random R4"); end
        6:          send_sym(ST, "random R5 R7");
        7:          send_sym(SR, "random R5");
        8:          send_ones(10, "random R3");
        default:    send_sym(5'($urandom), "random R2 R8 R9 R10");
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule